// File: doc/BRIEF.md
# PCIe Receive TLP Router

This block sits on the receive side of a PCI Express transaction layer, after the link and data-link layers. Each incoming TLP arrives as a stream of 32-bit dwords: a 3- or 4-dword header followed by any payload. From the header the block decides where the packet goes. The choices are the application receive interface, the internal configuration space, the internal message handler, or the discard path for Unsupported Requests. It then steers the payload beats to match. The routing table depends on a mode pin that selects endpoint or root-port behaviour. Memory and I/O requests are compared against up to six programmed base-address windows.

The verdict is registered once per packet, one cycle after the last header dword is accepted. A route code and a valid flag carry it, and they stay fixed until the packet's last beat. An Unsupported Request raises a one-cycle error-update pulse. A completion-request pulse marks a packet for which the core itself must return a completion: either a configuration request it serves, or a non-posted Unsupported Request.

Stream rules: a beat moves when `in_valid` and `in_ready` are both high at a rising clock edge. Header beats, and payload of packets that do not go to the application, are always accepted. For application payload, `in_ready` follows `app_ready`, so the application side back-pressures the link side directly. While stalled, `in_dw`, `in_sop` and `in_eop` must be held.

Top module: `pcie_rx_router`

## Requirements
- R1: Header dword 0 carries the format in bits 31:29 and the type in bits 28:24. Format bit 29 set means a 4-dword header, otherwise 3. Format bit 30 set means a payload follows. `route_valid` rises in the cycle after the last header dword is accepted.
- R2: Route codes are 0 = application, 1 = configuration space, 2 = internal message handler, 3 = Unsupported Request. A memory request (type 0) routes to 0 when its address falls in an enabled memory window, where (address AND mask) equals (base AND mask). It raises neither pulse.
- R3: An I/O request (type 2) may only hit windows flagged as I/O, and a memory request only windows not so flagged. A miss, including a miss on window type, gives code 3 with an error pulse. A completion is requested for reads and I/O requests but not for posted memory writes.
- R4: With a 3-dword header the address is dword 2 with zero upper bits. With a 4-dword header the address is dword 2 (upper) concatenated with dword 3 (lower), compared over 64 bits.
- R5: A Type 0 configuration request (type 4) gives code 1 with a completion pulse and no error in endpoint mode. In root-port mode it gives code 3 with both pulses. A Type 1 configuration request (type 5) and a locked memory read (type 1) always give code 3 with both pulses.
- R6: Messages have type bits 28:27 = 2'b10 and a message code in dword 1 bits 7:0. Vendor-defined codes 0x7E and 0x7F route to code 0 in both modes, with or without payload.
- R7: Power-management codes 0x14, 0x18, 0x19 and 0x1B, and slot power limit 0x50, give code 2 in both modes.
- R8: Indicator codes 0x40, 0x41, 0x43, 0x44, 0x45 and 0x47 give code 2 in endpoint mode and code 3 in root-port mode. Button-press code 0x48 gives code 2 in root-port mode and code 3 in endpoint mode.
- R9: Unlock code 0x00 gives code 2 only in endpoint mode. Interrupt codes 0x20 to 0x27 and error codes 0x30, 0x31 and 0x33 give code 2 only in root-port mode. Any message not supported in the current mode gives code 3 with an error pulse and no completion pulse.
- R10: `route_code` holds from the rise of `route_valid` through the cycle in which the packet's last beat is accepted. `route_valid` falls after that cycle, or one cycle after rising for a header-only packet.
- R11: Payload beats of a code 0 packet appear on `app_valid`/`app_dw`, with `in_ready` equal to `app_ready`. Payload beats of a code 3 packet pulse `drop_beat` and never appear on `app_valid`. Beats of code 1 and code 2 packets are consumed with neither strobe.
- R12: `in_ready` is high for every header beat and for all payload not routed to the application.
- R13: After reset, `route_valid`, `ur_err`, `cpl_req`, `app_valid` and `drop_beat` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_mode | input | 1 | 1 = endpoint table, 0 = root-port table; change only between packets |
| win_en | input | NUM_WIN | Per-window enable |
| win_io | input | NUM_WIN | Per-window I/O flag (1 = I/O window, 0 = memory window) |
| win_base | input | NUM_WIN x 64 | Per-window base address |
| win_mask | input | NUM_WIN x 64 | Per-window compare mask (1 = compared bit) |
| in_valid | input | 1 | Incoming beat valid |
| in_ready | output | 1 | Incoming beat accepted |
| in_sop | input | 1 | First header dword of a packet |
| in_eop | input | 1 | Last dword of a packet |
| in_dw | input | 32 | Incoming dword |
| app_valid | output | 1 | Payload beat offered to the application |
| app_ready | input | 1 | Application accepts payload beat |
| app_dw | output | 32 | Payload dword to the application |
| app_eop | output | 1 | Last payload beat to the application |
| drop_beat | output | 1 | Payload beat of an Unsupported Request discarded |
| route_valid | output | 1 | Verdict present for current packet |
| route_code | output | 2 | Verdict: 0 app, 1 config, 2 internal message, 3 unsupported |
| ur_err | output | 1 | One-cycle error-bit update pulse |
| cpl_req | output | 1 | One-cycle request for a core-generated completion |

## Verification
On every cycle, assertions check the following. An error pulse only ever accompanies a code 3 verdict. A completion pulse never accompanies an application route. The route code stays unchanged while a verdict is held. Dropped beats are never stalled, and no packet may start in the middle of a header. The scenarios are the only way to show that each message code, window type and address width lands on the right code in each mode. They also show that payload beat counts reach the application or the drop strobe as expected, and that application back-pressure really stalls the link side.

// File: rtl/pcie_rx_route_pkg.sv
package pcie_rx_route_pkg;

  typedef enum logic [1:0] {
    RT_APP = 2'd0,
    RT_CFG = 2'd1,
    RT_INT = 2'd2,
    RT_UR  = 2'd3
  } route_e;

  typedef enum logic [2:0] {
    K_MEM,
    K_LOCK,
    K_IO,
    K_CFG0,
    K_CFG1,
    K_MSG,
    K_OTHER
  } kind_e;

  typedef struct packed {
    route_e route;
    logic   err;
    logic   cpl;
  } verdict_t;

  localparam logic [4:0] TY_MEM  = 5'b00000;
  localparam logic [4:0] TY_LOCK = 5'b00001;
  localparam logic [4:0] TY_IO   = 5'b00010;
  localparam logic [4:0] TY_CFG0 = 5'b00100;
  localparam logic [4:0] TY_CFG1 = 5'b00101;

  function automatic kind_e kind_of(input logic [2:0] fmt, input logic [4:0] typ);
    kind_e k;
    if (fmt[2])                 k = K_OTHER;
    else if (typ == TY_MEM)     k = K_MEM;
    else if (typ == TY_LOCK)    k = K_LOCK;
    else if (typ == TY_IO)      k = K_IO;
    else if (typ == TY_CFG0)    k = K_CFG0;
    else if (typ == TY_CFG1)    k = K_CFG1;
    else if (typ[4:3] == 2'b10) k = K_MSG;
    else                        k = K_OTHER;
    return k;
  endfunction

  // Message code table, per mode
  function automatic route_e msg_route(input logic [7:0] code, input logic ep);
    route_e r;
    unique casez (code)
      8'h7E, 8'h7F:                   r = RT_APP;
      8'h14, 8'h18, 8'h19, 8'h1B,
      8'h50:                          r = RT_INT;
      8'h40, 8'h41, 8'h43, 8'h44,
      8'h45, 8'h47:                   r = ep ? RT_INT : RT_UR;
      8'h48:                          r = ep ? RT_UR : RT_INT;
      8'h00:                          r = ep ? RT_INT : RT_UR;
      8'b0010_0???:                   r = ep ? RT_UR : RT_INT;
      8'h30, 8'h31, 8'h33:            r = ep ? RT_UR : RT_INT;
      default:                        r = RT_UR;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rx_hdr_collect.sv
module rx_hdr_collect #(
  parameter int DW_W    = 32,
  parameter int MAX_HDR = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdr_fire,
  input  logic                      in_sop,
  input  logic [DW_W-1:0]           in_dw,
  output logic                      at_last,
  output logic [MAX_HDR-1:0][DW_W-1:0] hdr_view
);
  localparam int IW = $clog2(MAX_HDR);

  logic [IW-1:0]   idx;
  logic [DW_W-1:0] held [MAX_HDR-1];
  logic            four_dw;

  assign four_dw = (idx == '0) ? in_dw[29] : held[0][29];
  assign at_last = four_dw ? (idx == IW'(MAX_HDR-1)) : (idx == IW'(MAX_HDR-2));

  generate
    for (genvar k = 0; k < MAX_HDR; k++) begin : g_view
      if (k < MAX_HDR-1) begin : g_held
        assign hdr_view[k] = (idx == IW'(k)) ? in_dw : held[k];
      end else begin : g_live
        assign hdr_view[k] = in_dw;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      for (int k = 0; k < MAX_HDR-1; k++) held[k] <= '0;
    end else if (hdr_fire) begin
      idx <= at_last ? '0 : idx + 1'b1;
      for (int k = 0; k < MAX_HDR-1; k++)
        if (idx == IW'(k)) held[k] <= in_dw;
    end
  end

  // R1
  sop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |-> (in_sop == (idx == '0)));

endmodule

// File: rtl/rx_win_match.sv
module rx_win_match #(
  parameter int NUM_WIN = 6,
  parameter int AW      = 64
) (
  input  logic [AW-1:0]               addr,
  input  logic                        want_io,
  input  logic [NUM_WIN-1:0]          win_en,
  input  logic [NUM_WIN-1:0]          win_io,
  input  logic [NUM_WIN-1:0][AW-1:0]  win_base,
  input  logic [NUM_WIN-1:0][AW-1:0]  win_mask,
  output logic                        hit
);
  logic [NUM_WIN-1:0] hit_vec;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      assign hit_vec[w] = win_en[w] && (win_io[w] == want_io) &&
                          ((addr & win_mask[w]) == (win_base[w] & win_mask[w]));
    end
  endgenerate

  assign hit = |hit_vec;
endmodule

// File: rtl/rx_route_decide.sv
module rx_route_decide
  import pcie_rx_route_pkg::*;
#(
  parameter int DW_W = 32,
  parameter int AW   = 64
) (
  input  logic [3:0][DW_W-1:0] hdr,
  input  logic                 ep_mode,
  input  logic                 win_hit,
  output logic [AW-1:0]        req_addr,
  output logic                 req_io,
  output verdict_t             verdict
);
  logic [2:0] fmt;
  logic [4:0] typ;
  logic       has_data;
  kind_e      kind;
  route_e     mroute;

  assign fmt      = hdr[0][31:29];
  assign typ      = hdr[0][28:24];
  assign has_data = fmt[1];
  assign kind     = kind_of(fmt, typ);
  assign req_io   = (kind == K_IO);
  assign req_addr = fmt[0] ? AW'({hdr[2], hdr[3]}) : AW'(hdr[2]);
  assign mroute   = msg_route(hdr[1][7:0], ep_mode);

  always_comb begin
    verdict = '{route: RT_UR, err: 1'b1, cpl: 1'b0};
    unique case (kind)
      K_MEM: begin
        if (win_hit) verdict = '{route: RT_APP, err: 1'b0, cpl: 1'b0};
        else         verdict = '{route: RT_UR,  err: 1'b1, cpl: !has_data};
      end
      K_IO: begin
        if (win_hit) verdict = '{route: RT_APP, err: 1'b0, cpl: 1'b0};
        else         verdict = '{route: RT_UR,  err: 1'b1, cpl: 1'b1};
      end
      K_CFG0: begin
        if (ep_mode) verdict = '{route: RT_CFG, err: 1'b0, cpl: 1'b1};
        else         verdict = '{route: RT_UR,  err: 1'b1, cpl: 1'b1};
      end
      K_CFG1, K_LOCK: verdict = '{route: RT_UR, err: 1'b1, cpl: 1'b1};
      K_MSG:  verdict = '{route: mroute, err: (mroute == RT_UR), cpl: 1'b0};
      default: verdict = '{route: RT_UR, err: 1'b1, cpl: 1'b0};
    endcase
  end
endmodule

// File: rtl/pcie_rx_router.sv
module pcie_rx_router
  import pcie_rx_route_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int AW      = 64,
  parameter int DW_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ep_mode,
  input  logic [NUM_WIN-1:0]          win_en,
  input  logic [NUM_WIN-1:0]          win_io,
  input  logic [NUM_WIN-1:0][AW-1:0]  win_base,
  input  logic [NUM_WIN-1:0][AW-1:0]  win_mask,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sop,
  input  logic                        in_eop,
  input  logic [DW_W-1:0]             in_dw,
  output logic                        app_valid,
  input  logic                        app_ready,
  output logic [DW_W-1:0]             app_dw,
  output logic                        app_eop,
  output logic                        drop_beat,
  output logic                        route_valid,
  output logic [1:0]                  route_code,
  output logic                        ur_err,
  output logic                        cpl_req
);
  localparam int MAX_HDR = 4;

  logic                        pkt_open;
  logic                        route_new;
  route_e                      route_q;
  logic                        hdr_fire, pay_fire, pay_end, last_fire, at_last;
  logic [MAX_HDR-1:0][DW_W-1:0] hdr_view;
  logic [AW-1:0]               req_addr;
  logic                        req_io, win_hit;
  verdict_t                    verdict;

  rx_hdr_collect #(.DW_W(DW_W), .MAX_HDR(MAX_HDR)) u_collect (
    .clk(clk), .rst_n(rst_n), .hdr_fire(hdr_fire), .in_sop(in_sop),
    .in_dw(in_dw), .at_last(at_last), .hdr_view(hdr_view)
  );

  rx_win_match #(.NUM_WIN(NUM_WIN), .AW(AW)) u_match (
    .addr(req_addr), .want_io(req_io), .win_en(win_en), .win_io(win_io),
    .win_base(win_base), .win_mask(win_mask), .hit(win_hit)
  );

  rx_route_decide #(.DW_W(DW_W), .AW(AW)) u_decide (
    .hdr(hdr_view), .ep_mode(ep_mode), .win_hit(win_hit),
    .req_addr(req_addr), .req_io(req_io), .verdict(verdict)
  );

  // Stream gating
  assign in_ready  = (pkt_open && route_q == RT_APP) ? app_ready : 1'b1;
  assign hdr_fire  = in_valid && !pkt_open;
  assign pay_fire  = in_valid && in_ready && pkt_open;
  assign pay_end   = pay_fire && in_eop;
  assign last_fire = hdr_fire && at_last;

  assign app_valid = in_valid && pkt_open && (route_q == RT_APP);
  assign app_dw    = in_dw;
  assign app_eop   = in_eop;
  assign drop_beat = in_valid && pkt_open && (route_q == RT_UR);

  assign route_code = route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_open    <= 1'b0;
      route_valid <= 1'b0;
      route_new   <= 1'b0;
      route_q     <= RT_APP;
      ur_err      <= 1'b0;
      cpl_req     <= 1'b0;
    end else begin
      route_new <= last_fire;
      ur_err    <= last_fire && verdict.err;
      cpl_req   <= last_fire && verdict.cpl;
      if (last_fire) begin
        route_q     <= verdict.route;
        route_valid <= 1'b1;
        pkt_open    <= !in_eop;
      end else begin
        route_valid <= pkt_open && !pay_end;
        pkt_open    <= pkt_open && !pay_end;
      end
    end
  end

  // R3
  err_is_ur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ur_err |-> (route_valid && route_code == RT_UR));

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ur_err |=> !ur_err);

  // R5
  cpl_not_app_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_req |-> (route_valid && route_code != RT_APP));

  // R10
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_valid && !route_new) |-> $stable(route_code));

  // R11
  drop_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_beat |-> (in_ready && !app_valid));

  // R12
  hdr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !route_valid |-> in_ready);

endmodule

// File: tb/pcie_rx_router_test.sv
module pcie_rx_router_test;
  localparam int NW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ep_mode = 1'b1;
  logic [NW-1:0] win_en, win_io;
  logic [NW-1:0][63:0] win_base, win_mask;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_dw = '0;
  logic app_ready = 1'b1;
  logic in_ready, app_valid, app_eop, drop_beat, route_valid, ur_err, cpl_req;
  logic [31:0] app_dw;
  logic [1:0] route_code;

  always #5 clk = ~clk;

  pcie_rx_router #(.NUM_WIN(NW)) uut (
    .clk(clk), .rst_n(rst_n), .ep_mode(ep_mode), .win_en(win_en), .win_io(win_io),
    .win_base(win_base), .win_mask(win_mask), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_dw(in_dw), .app_valid(app_valid),
    .app_ready(app_ready), .app_dw(app_dw), .app_eop(app_eop), .drop_beat(drop_beat),
    .route_valid(route_valid), .route_code(route_code), .ur_err(ur_err), .cpl_req(cpl_req)
  );

  typedef struct { int id; logic [1:0] r; logic e; logic c; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, failures = 0;
  int app_seen = 0, drop_seen = 0, app_exp = 0, drop_exp = 0;
  logic prv = 1'b0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] h0(input logic [2:0] fmt, input logic [4:0] ty);
    return {fmt, ty, 14'd0, 10'd1};
  endfunction

  // Driver: pushes expectation, then sends header and payload beats
  task automatic send(input int id, input string req, input logic [31:0] d0, d1, d2, d3,
                      input int npay, input logic [1:0] er, input logic ee, ec);
    int nh;
    exp_t x;
    x.id = id; x.r = er; x.e = ee; x.c = ec; x.req = req;
    sb.push_back(x);
    nh = d0[29] ? 4 : 3;
    for (int b = 0; b < nh + npay; b++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (b == 0);
      in_eop   = (b == nh + npay - 1);
      in_dw    = (b == 0) ? d0 : (b == 1) ? d1 : (b == 2) ? d2 : (b == 3 && nh == 4) ? d3 : 32'hC0DE_0000 + b;
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (app_valid && app_ready) app_seen++;
      if (drop_beat) drop_seen++;
      if (route_valid && !prv) begin
        if (sb.size() == 0) chk(0, "R10", "unexpected verdict", route_code, 0);
        else begin
          exp_t x;
          x = sb.pop_front();
          chk(route_code == x.r, x.req, $sformatf("pkt%0d route", x.id), route_code, x.r);
          chk(ur_err == x.e, x.req, $sformatf("pkt%0d ur_err", x.id), ur_err, x.e);
          chk(cpl_req == x.c, x.req, $sformatf("pkt%0d cpl_req", x.id), cpl_req, x.c);
        end
      end else if (ur_err || cpl_req) begin
        chk(0, "R10", "pulse without new verdict", {ur_err, cpl_req}, 0);
      end
      prv = route_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "R10", "watchdog expired", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [4:0] MSG = 5'b10000, MSGR = 5'b10100;

  initial begin
    win_en = '0; win_io = '0; win_base = '0; win_mask = '0;
    win_en[0] = 1; win_base[0] = 64'h8000_0000; win_mask[0] = 64'hFFFF_FFFF_FFFF_F000;
    win_en[1] = 1; win_io[1] = 1; win_base[1] = 64'h1000; win_mask[1] = 64'hFFFF_FFFF_FFFF_FF00;
    win_en[2] = 1; win_base[2] = 64'h1_0000_0000; win_mask[2] = 64'hFFFF_FFFF_FFF0_0000;
    win_base[3] = 64'h9000_0000; win_mask[3] = 64'hFFFF_FFFF_FFFF_F000; // disabled window

    repeat (3) @(negedge clk);
    // R13 reset state
    chk(route_valid == 0, "R13", "route_valid", route_valid, 0);
    chk(ur_err == 0 && cpl_req == 0, "R13", "pulses", {ur_err, cpl_req}, 0);
    chk(in_ready == 1, "R13", "in_ready", in_ready, 1);
    chk(app_valid == 0 && drop_beat == 0, "R13", "strobes", {app_valid, drop_beat}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Endpoint mode
    send(1,  "R2",  h0(3'b010, 5'd0), 0, 32'h8000_0010, 0, 2, 2'd0, 0, 0);
    send(2,  "R2",  h0(3'b000, 5'd0), 0, 32'h8000_0FF0, 0, 0, 2'd0, 0, 0);
    send(3,  "R3",  h0(3'b000, 5'd0), 0, 32'h9000_0000, 0, 0, 2'd3, 1, 1);
    send(4,  "R3",  h0(3'b010, 5'd0), 0, 32'h8000_1000, 0, 3, 2'd3, 1, 0);
    send(5,  "R3",  h0(3'b000, 5'd2), 0, 32'h0000_1010, 0, 0, 2'd0, 0, 0);
    send(6,  "R3",  h0(3'b000, 5'd0), 0, 32'h0000_1010, 0, 0, 2'd3, 1, 1);
    send(7,  "R3",  h0(3'b010, 5'd2), 0, 32'h8000_0010, 0, 1, 2'd3, 1, 1);
    send(8,  "R4",  h0(3'b001, 5'd0), 0, 32'h1, 32'h40, 0, 2'd0, 0, 0);
    send(9,  "R4",  h0(3'b011, 5'd0), 0, 32'h2, 32'h40, 1, 2'd3, 1, 0);
    send(10, "R5",  h0(3'b000, 5'd1), 0, 32'h8000_0010, 0, 0, 2'd3, 1, 1);
    send(11, "R5",  h0(3'b000, 5'd4), 0, 0, 0, 0, 2'd1, 0, 1);
    send(12, "R5",  h0(3'b010, 5'd4), 0, 0, 0, 1, 2'd1, 0, 1);
    send(13, "R5",  h0(3'b000, 5'd5), 0, 0, 0, 0, 2'd3, 1, 1);
    send(14, "R6",  h0(3'b001, MSG),  32'h7E, 0, 0, 0, 2'd0, 0, 0);
    send(15, "R6",  h0(3'b011, MSGR), 32'h7F, 0, 0, 2, 2'd0, 0, 0);
    send(16, "R7",  h0(3'b001, MSG),  32'h18, 0, 0, 0, 2'd2, 0, 0);
    send(17, "R7",  h0(3'b011, MSGR), 32'h50, 0, 0, 1, 2'd2, 0, 0);
    send(18, "R8",  h0(3'b001, MSGR), 32'h41, 0, 0, 0, 2'd2, 0, 0);
    send(19, "R9",  h0(3'b001, MSGR), 32'h00, 0, 0, 0, 2'd2, 0, 0);
    send(20, "R9",  h0(3'b001, MSG),  32'h33, 0, 0, 0, 2'd3, 1, 0);
    send(21, "R9",  h0(3'b001, MSGR), 32'h20, 0, 0, 0, 2'd3, 1, 0);
    send(22, "R8",  h0(3'b001, MSG),  32'h48, 0, 0, 0, 2'd3, 1, 0);
    send(23, "R9",  h0(3'b001, MSG),  32'h60, 0, 0, 0, 2'd3, 1, 0);

    // R11 application back-pressure
    app_ready = 1'b0;
    fork
      send(24, "R11", h0(3'b010, 5'd0), 0, 32'h8000_0100, 0, 4, 2'd0, 0, 0);
      begin
        repeat (6) @(negedge clk);
        #2;
        chk(in_ready == 0, "R11", "stalled in_ready", in_ready, 0);
        chk(app_valid == 1, "R11", "stalled app_valid", app_valid, 1);
        chk(route_valid == 1 && route_code == 2'd0, "R10", "held route", route_code, 0);
        app_ready = 1'b1;
      end
    join

    // Root-port mode
    @(negedge clk);
    ep_mode = 1'b0;
    send(25, "R5",  h0(3'b000, 5'd4), 0, 0, 0, 0, 2'd3, 1, 1);
    send(26, "R9",  h0(3'b001, MSG),  32'h30, 0, 0, 0, 2'd2, 0, 0);
    send(27, "R9",  h0(3'b001, MSGR), 32'h27, 0, 0, 0, 2'd2, 0, 0);
    send(28, "R9",  h0(3'b001, MSGR), 32'h00, 0, 0, 0, 2'd3, 1, 0);
    send(29, "R8",  h0(3'b001, MSGR), 32'h47, 0, 0, 0, 2'd3, 1, 0);
    send(30, "R8",  h0(3'b001, MSG),  32'h48, 0, 0, 0, 2'd2, 0, 0);
    send(31, "R6",  h0(3'b011, MSG),  32'h7E, 0, 0, 1, 2'd0, 0, 0);
    send(32, "R7",  h0(3'b001, MSG),  32'h1B, 0, 0, 0, 2'd2, 0, 0);
    send(33, "R2",  h0(3'b000, 5'd0), 0, 32'h8000_0004, 0, 0, 2'd0, 0, 0);

    repeat (4) @(negedge clk);
    app_exp = 2 + 2 + 4 + 1;
    drop_exp = 3 + 1 + 1;
    chk(app_seen == app_exp, "R11", "app beats", app_seen, app_exp);
    chk(drop_seen == drop_exp, "R11", "dropped beats", drop_seen, drop_exp);
    chk(sb.size() == 0, "R1", "verdicts outstanding", sb.size(), 0);
    chk(route_valid == 0 && in_ready == 1, "R12", "idle after traffic", {route_valid, in_ready}, 1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule